// File: doc/BRIEF.md
# APB3 Address-Decoding Bus Splitter

This block connects one upstream APB3 requester to several downstream APB3 completers. Each downstream port owns a contiguous address window, defined by a base and a size in a parameter table. The block decodes the incoming address and raises the select line of exactly one downstream port, the one whose window contains the address. That port receives the enable, direction, write data and an address rebased to the window's own offset. The selected port's ready, error and read data are routed back upstream, so a slow completer stretches the transfer in the usual APB way.

An address that falls inside no window selects nothing downstream. The block answers such a transfer itself: the access phase completes with ready and error both high. The address decode itself is combinational, so the setup and access phases pass straight through. A single register records that the setup phase of a transfer missed every window, and the local error reply is driven from that register.

Top module: `apb_region_splitter`

## Requirements
- R1: In the setup phase (upstream select high, enable low), the selected downstream port sees select high and enable low, and the direction and write data equal the upstream values.
- R2: In the access phase (upstream select and enable high), the selected port sees select and enable both high, and its address keeps the value it had in setup. No unselected port ever sees enable high.
- R3: At most one downstream select is high at any time, and every port other than the decoded one keeps its select low for the whole transfer.
- R4: Port i's window covers addresses A with base_i <= A < base_i + size_i. The address driven to the selected port is A - base_i, which is the same as (A - base_i) modulo size_i for any address inside the window. The defaults are: port 0 at 0x0000 with size 0x100, port 1 at 0x1000 with size 0x1000, port 2 at 0x2000 with size 0x800, and port 3 at 0x3000 with size 0x400.
- R5: Upstream ready and error equal those of the selected port. While that port holds ready low, upstream ready stays low and the transfer is stretched.
- R6: On a read, upstream read data equals the selected port's read data when that port signals ready.
- R7: An address outside every window selects no port. Upstream ready is low in its setup cycle. In the first access cycle that follows, upstream ready and error are both high.
- R8: With upstream select low, all downstream selects and enables are low, and upstream ready, error and read data are zero, whatever the downstream ports drive.
- R9: When windows overlap, the lowest-numbered matching port is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the upstream interface |
| rstN | input | 1 | Asynchronous reset, active low |
| upSel | input | 1 | Upstream select |
| upEnable | input | 1 | Upstream enable (access phase) |
| upWrite | input | 1 | Upstream direction, 1 = write |
| upAddr | input | AddrW | Upstream address |
| upWdata | input | DataW | Upstream write data |
| upRdata | output | DataW | Read data returned upstream |
| upReady | output | 1 | Ready returned upstream |
| upSlvErr | output | 1 | Error returned upstream |
| dnSel | output | NumPorts | Per-port select |
| dnEnable | output | NumPorts | Per-port enable |
| dnWrite | output | 1 | Direction broadcast to all ports |
| dnAddr | output | NumPorts x AddrW | Per-port rebased address |
| dnWdata | output | DataW | Write data broadcast to all ports |
| dnRdata | input | NumPorts x DataW | Per-port read data |
| dnReady | input | NumPorts | Per-port ready |
| dnSlvErr | input | NumPorts | Per-port error |

## Verification
The assertions assume that the requester follows APB3:
- a transfer always opens with a setup cycle;
- the address stays constant from setup until the access phase completes;
- enable is never high without select.

The local error check and the stability checks depend on these assumptions. The random stimulus is generated through one transfer task, which always drives a setup cycle, holds the address and direction until ready, and then drops select. Addresses are drawn mostly inside the windows, with a share drawn at random across the whole space to produce misses. Directed cases cover each window's first and last address, the addresses just past them, and an overlapping table.

// File: rtl/apb_split_pkg.sv
package apb_split_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic xferActive;   // upstream select is high
    logic accessPhase;  // upstream select and enable are high
    logic errAck;       // complete an unmapped access locally
  } splitStrobes_t;

endpackage

// File: rtl/apb_split_ctrl.sv
module apb_split_ctrl
  import apb_split_pkg::*;
#(
  parameter int NumPorts = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                upSel,
  input  logic                upEnable,
  input  logic [NumPorts-1:0] inRange,
  output logic [NumPorts-1:0] grant,
  output splitStrobes_t       strobes
);

  logic [NumPorts-1:0] prioHit;
  logic                found;
  logic                miss;
  logic                missArmed;
  logic                missArmedNext;

  // Lowest-numbered window wins when windows overlap
  always_comb begin
    prioHit = '0;
    found   = 1'b0;
    for (int i = 0; i < NumPorts; i++) begin
      if (!found && inRange[i]) begin
        prioHit[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign grant = upSel ? prioHit : '0;
  assign miss  = upSel && !found;

  // Armed by a missed cycle, cleared once the local error reply is given
  assign missArmedNext = miss && !(upEnable && missArmed);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      missArmed <= 1'b0;
    end else begin
      missArmed <= missArmedNext;
    end
  end

  always_comb begin
    strobes.xferActive  = upSel;
    strobes.accessPhase = upSel && upEnable;
    strobes.errAck      = upSel && upEnable && missArmed;
  end

endmodule

// File: rtl/apb_split_dpath.sv
module apb_split_dpath
  import apb_split_pkg::*;
#(
  parameter int NumPorts = 4,
  parameter int AddrW    = 16,
  parameter int DataW    = 32,
  parameter logic [NumPorts-1:0][AddrW-1:0] RegionBase = '0,
  parameter logic [NumPorts-1:0][AddrW-1:0] RegionSize = '0
) (
  input  logic                            upWrite,
  input  logic [AddrW-1:0]                upAddr,
  input  logic [DataW-1:0]                upWdata,
  input  logic [NumPorts-1:0]             grant,
  input  splitStrobes_t                   strobes,
  input  logic [NumPorts-1:0][DataW-1:0]  dnRdata,
  input  logic [NumPorts-1:0]             dnReady,
  input  logic [NumPorts-1:0]             dnSlvErr,
  output logic [NumPorts-1:0]             inRange,
  output logic [NumPorts-1:0]             dnSel,
  output logic [NumPorts-1:0]             dnEnable,
  output logic                            dnWrite,
  output logic [NumPorts-1:0][AddrW-1:0]  dnAddr,
  output logic [DataW-1:0]                dnWdata,
  output logic [DataW-1:0]                upRdata,
  output logic                            upReady,
  output logic                            upSlvErr
);

  logic [NumPorts-1:0][AddrW-1:0] offset;
  logic [NumPorts-1:0][DataW-1:0] rdataMasked;

  // One window comparator and rebaser per port
  for (genvar g = 0; g < NumPorts; g++) begin : g_port
    assign offset[g]      = upAddr - RegionBase[g];
    assign inRange[g]     = (upAddr >= RegionBase[g]) && (offset[g] < RegionSize[g]);
    assign dnSel[g]       = grant[g];
    assign dnEnable[g]    = grant[g] && strobes.accessPhase;
    assign dnAddr[g]      = grant[g] ? offset[g] : '0;
    assign rdataMasked[g] = grant[g] ? dnRdata[g] : '0;
  end

  assign dnWrite = upWrite && strobes.xferActive;
  assign dnWdata = upWdata;

  // AND-OR return path: grant is one-hot or zero
  always_comb begin
    upRdata = '0;
    for (int i = 0; i < NumPorts; i++) begin
      upRdata = upRdata | rdataMasked[i];
    end
  end

  assign upReady  = (|(dnReady & grant)) || strobes.errAck;
  assign upSlvErr = (|(dnSlvErr & grant)) || strobes.errAck;

endmodule

// File: rtl/apb_region_splitter.sv
module apb_region_splitter
  import apb_split_pkg::*;
#(
  parameter int NumPorts = 4,
  parameter int AddrW    = 16,
  parameter int DataW    = 32,
  parameter logic [NumPorts-1:0][AddrW-1:0] RegionBase =
    {16'h3000, 16'h2000, 16'h1000, 16'h0000},
  parameter logic [NumPorts-1:0][AddrW-1:0] RegionSize =
    {16'h0400, 16'h0800, 16'h1000, 16'h0100}
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            upSel,
  input  logic                            upEnable,
  input  logic                            upWrite,
  input  logic [AddrW-1:0]                upAddr,
  input  logic [DataW-1:0]                upWdata,
  output logic [DataW-1:0]                upRdata,
  output logic                            upReady,
  output logic                            upSlvErr,
  output logic [NumPorts-1:0]             dnSel,
  output logic [NumPorts-1:0]             dnEnable,
  output logic                            dnWrite,
  output logic [NumPorts-1:0][AddrW-1:0]  dnAddr,
  output logic [DataW-1:0]                dnWdata,
  input  logic [NumPorts-1:0][DataW-1:0]  dnRdata,
  input  logic [NumPorts-1:0]             dnReady,
  input  logic [NumPorts-1:0]             dnSlvErr
);

  logic [NumPorts-1:0] inRange;
  logic [NumPorts-1:0] grant;
  splitStrobes_t       strobes;

  apb_split_ctrl #(
    .NumPorts(NumPorts)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .upSel    (upSel),
    .upEnable (upEnable),
    .inRange  (inRange),
    .grant    (grant),
    .strobes  (strobes)
  );

  apb_split_dpath #(
    .NumPorts   (NumPorts),
    .AddrW      (AddrW),
    .DataW      (DataW),
    .RegionBase (RegionBase),
    .RegionSize (RegionSize)
  ) u_dpath (
    .upWrite  (upWrite),
    .upAddr   (upAddr),
    .upWdata  (upWdata),
    .grant    (grant),
    .strobes  (strobes),
    .dnRdata  (dnRdata),
    .dnReady  (dnReady),
    .dnSlvErr (dnSlvErr),
    .inRange  (inRange),
    .dnSel    (dnSel),
    .dnEnable (dnEnable),
    .dnWrite  (dnWrite),
    .dnAddr   (dnAddr),
    .dnWdata  (dnWdata),
    .upRdata  (upRdata),
    .upReady  (upReady),
    .upSlvErr (upSlvErr)
  );

endmodule

// File: rtl/apb_split_chk.sv
module apb_split_chk #(
  parameter int NumPorts = 4,
  parameter int AddrW    = 16,
  parameter int DataW    = 32
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            upSel,
  input logic                            upEnable,
  input logic [AddrW-1:0]                upAddr,
  input logic [DataW-1:0]                upRdata,
  input logic                            upReady,
  input logic                            upSlvErr,
  input logic [NumPorts-1:0]             dnSel,
  input logic [NumPorts-1:0]             dnEnable,
  input logic [NumPorts-1:0][AddrW-1:0]  dnAddr,
  input logic [NumPorts-1:0]             dnReady,
  input logic [NumPorts-1:0]             dnSlvErr
);

  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dnSel));

  p_enable_only_selected_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dnEnable & ~dnSel) == '0);

  p_setup_to_access_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (upSel && !upEnable && dnSel != '0) ##1 (upSel && upEnable && $stable(upAddr))
      |-> ($stable(dnSel) && $stable(dnAddr) && dnEnable == dnSel));

  p_ready_mirror_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dnSel != '0) |-> (upReady == |(dnReady & dnSel)) && (upSlvErr == |(dnSlvErr & dnSel)));

  p_unmapped_error_r7: assert property (@(posedge clk) disable iff (!rstN)
    (upSel && !upEnable && dnSel == '0) ##1 (upSel && upEnable && $stable(upAddr))
      |-> (upReady && upSlvErr && dnSel == '0));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !upSel |-> (dnSel == '0 && dnEnable == '0 && !upReady && !upSlvErr && upRdata == '0));

endmodule

bind apb_region_splitter apb_split_chk #(
  .NumPorts(NumPorts), .AddrW(AddrW), .DataW(DataW)
) u_chk (
  .clk(clk), .rstN(rstN), .upSel(upSel), .upEnable(upEnable), .upAddr(upAddr),
  .upRdata(upRdata), .upReady(upReady), .upSlvErr(upSlvErr), .dnSel(dnSel),
  .dnEnable(dnEnable), .dnAddr(dnAddr), .dnReady(dnReady), .dnSlvErr(dnSlvErr)
);

// File: tb/test_apb_region_splitter.sv
module test_apb_region_splitter;

  localparam int ClkPeriod = 10;
  localparam int NumPorts  = 4;
  localparam int AddrW     = 16;
  localparam int DataW     = 32;
  localparam logic [NumPorts-1:0][AddrW-1:0] BaseTbl =
    {16'h3000, 16'h2000, 16'h1000, 16'h0000};
  localparam logic [NumPorts-1:0][AddrW-1:0] SizeTbl =
    {16'h0400, 16'h0800, 16'h1000, 16'h0100};

  logic clk = 1'b0;
  logic rstN;
  logic upSel, upEnable, upWrite;
  logic [AddrW-1:0] upAddr;
  logic [DataW-1:0] upWdata, upRdata;
  logic upReady, upSlvErr;
  logic [NumPorts-1:0] dnSel, dnEnable, dnReady, dnSlvErr;
  logic dnWrite;
  logic [NumPorts-1:0][AddrW-1:0] dnAddr;
  logic [DataW-1:0] dnWdata;
  logic [NumPorts-1:0][DataW-1:0] dnRdata;

  // Second instance with overlapping windows
  logic ovSel;
  logic [AddrW-1:0] ovAddr;
  logic [DataW-1:0] ovRdata;
  logic ovReady, ovSlvErr, ovWrite;
  logic [1:0] ovDnSel, ovDnEnable;
  logic [1:0][AddrW-1:0] ovDnAddr;
  logic [DataW-1:0] ovDnWdata;

  int checks = 0;
  int errors = 0;

  always #(ClkPeriod/2) clk = ~clk;

  apb_region_splitter #(
    .NumPorts(NumPorts), .AddrW(AddrW), .DataW(DataW),
    .RegionBase(BaseTbl), .RegionSize(SizeTbl)
  ) i_apb_region_splitter (
    .clk(clk), .rstN(rstN), .upSel(upSel), .upEnable(upEnable), .upWrite(upWrite),
    .upAddr(upAddr), .upWdata(upWdata), .upRdata(upRdata), .upReady(upReady),
    .upSlvErr(upSlvErr), .dnSel(dnSel), .dnEnable(dnEnable), .dnWrite(dnWrite),
    .dnAddr(dnAddr), .dnWdata(dnWdata), .dnRdata(dnRdata), .dnReady(dnReady),
    .dnSlvErr(dnSlvErr)
  );

  apb_region_splitter #(
    .NumPorts(2), .AddrW(AddrW), .DataW(DataW),
    .RegionBase({16'h0000, 16'h1000}), .RegionSize({16'h8000, 16'h0100})
  ) i_apb_region_splitter_ovl (
    .clk(clk), .rstN(rstN), .upSel(ovSel), .upEnable(1'b0), .upWrite(1'b0),
    .upAddr(ovAddr), .upWdata('0), .upRdata(ovRdata), .upReady(ovReady),
    .upSlvErr(ovSlvErr), .dnSel(ovDnSel), .dnEnable(ovDnEnable), .dnWrite(ovWrite),
    .dnAddr(ovDnAddr), .dnWdata(ovDnWdata), .dnRdata('0), .dnReady(2'b00),
    .dnSlvErr(2'b00)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected port for an address: lowest-numbered matching window, -1 on miss
  function automatic int expPort(input logic [AddrW-1:0] a);
    for (int i = 0; i < NumPorts; i++) begin
      if (a >= BaseTbl[i] && (32'(a) < 32'(BaseTbl[i]) + 32'(SizeTbl[i]))) return i;
    end
    return -1;
  endfunction

  task automatic runXfer(input logic [AddrW-1:0] a, input bit wr, input int waits, input bit err);
    int p;
    logic [DataW-1:0] wd;
    logic [NumPorts-1:0] expSel;
    logic [AddrW-1:0] expOff;
    p = expPort(a);
    wd = $urandom;
    expSel = (p >= 0) ? NumPorts'(1) << p : '0;
    expOff = (p >= 0) ? a - BaseTbl[p] : '0;
    @(negedge clk);
    upSel = 1'b1; upEnable = 1'b0; upAddr = a; upWrite = wr; upWdata = wd;
    dnReady = '0; dnSlvErr = '0;
    for (int i = 0; i < NumPorts; i++) dnRdata[i] = $urandom;
    #2;
    chk("R3 setup select", 64'(dnSel), 64'(expSel));
    chk("R1 setup enable low", 64'(dnEnable), 64'd0);
    chk("R1 R7 setup ready low", 64'(upReady), 64'd0);
    if (p >= 0) begin
      chk("R1 direction", 64'(dnWrite), 64'(wr));
      chk("R1 write data", 64'(dnWdata), 64'(wd));
      chk("R4 rebased address", 64'(dnAddr[p]), 64'(expOff));
    end
    @(posedge clk); @(negedge clk);
    upEnable = 1'b1;
    if (p >= 0) begin
      for (int w = 0; w < waits; w++) begin
        #2;
        chk("R5 stretched ready low", 64'(upReady), 64'd0);
        chk("R2 access enable", 64'(dnEnable), 64'(expSel));
        chk("R2 address held", 64'(dnAddr[p]), 64'(expOff));
        @(posedge clk); @(negedge clk);
      end
      dnReady[p] = 1'b1; dnSlvErr[p] = err;
      #2;
      chk("R5 ready mirrored", 64'(upReady), 64'd1);
      chk("R5 error mirrored", 64'(upSlvErr), 64'(err));
      chk("R2 access select", 64'(dnSel), 64'(expSel));
      chk("R2 access enable", 64'(dnEnable), 64'(expSel));
      chk("R2 address held", 64'(dnAddr[p]), 64'(expOff));
      if (!wr) chk("R6 read data", 64'(upRdata), 64'(dnRdata[p]));
    end else begin
      #2;
      chk("R7 no select on miss", 64'(dnSel), 64'd0);
      chk("R7 local ready", 64'(upReady), 64'd1);
      chk("R7 local error", 64'(upSlvErr), 64'd1);
    end
    @(posedge clk); @(negedge clk);
    upSel = 1'b0; upEnable = 1'b0;
    dnReady = '1; dnSlvErr = '1;
    for (int i = 0; i < NumPorts; i++) dnRdata[i] = $urandom | 32'h1;
    #2;
    chk("R8 idle select", 64'(dnSel), 64'd0);
    chk("R8 idle ready", 64'(upReady), 64'd0);
    chk("R8 idle error", 64'(upSlvErr), 64'd0);
    chk("R8 idle read data", 64'(upRdata), 64'd0);
  endtask

  initial begin
    #(ClkPeriod * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r, k;
    logic [AddrW-1:0] a;
    void'($urandom(32'd20240611));
    rstN = 1'b0; upSel = 1'b0; upEnable = 1'b0; upWrite = 1'b0;
    upAddr = '0; upWdata = '0; dnRdata = '0; dnReady = '1; dnSlvErr = '1;
    ovSel = 1'b0; ovAddr = '0;
    repeat (3) @(negedge clk);
    #2;
    chk("R8 reset select", 64'(dnSel), 64'd0);
    chk("R8 reset ready", 64'(upReady), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed window edges and misses
    for (int i = 0; i < NumPorts; i++) begin
      runXfer(BaseTbl[i], 1'b1, 0, 1'b0);
      runXfer(BaseTbl[i] + SizeTbl[i] - 16'd1, 1'b0, 2, 1'b0);
      runXfer(BaseTbl[i] + SizeTbl[i], 1'b0, 1, 1'b1);
    end
    runXfer(16'hFFFF, 1'b1, 0, 1'b0);
    runXfer(16'h0100, 1'b0, 0, 1'b0);
    runXfer(16'h0100, 1'b1, 0, 1'b0);

    // R9 overlapping windows, lowest-numbered wins
    @(negedge clk);
    ovSel = 1'b1; ovAddr = 16'h1010;
    #2;
    chk("R9 overlap select", 64'(ovDnSel), 64'd1);
    chk("R9 overlap address", 64'(ovDnAddr[0]), 64'h10);
    @(negedge clk);
    ovAddr = 16'h2000;
    #2;
    chk("R9 outer window select", 64'(ovDnSel), 64'd2);
    chk("R9 outer window address", 64'(ovDnAddr[1]), 64'h2000);
    @(negedge clk);
    ovSel = 1'b0;

    // Constrained random transfers
    for (int n = 0; n < 300; n++) begin
      r = $urandom % 4;
      k = $urandom % NumPorts;
      if (r < 3) a = BaseTbl[k] + AddrW'($urandom % 32'(SizeTbl[k]));
      else a = AddrW'($urandom);
      runXfer(a, 1'($urandom), $urandom % 3, ($urandom % 4) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule